// File: doc/BRIEF.md
# Recycling Local Label Allocator

This block supplies segment labels to one slice of a streaming connected-components labeller. A label is requested only when a new foreground pixel has nothing but background around it. The block answers one cycle later with a plain label and an augmented label. Table lookups use the plain label. The augmented label puts the row number in which the label was handed out above the plain label. Comparing augmented labels therefore follows creation order, so the minimum-label rule still picks the older segment when recycled labels no longer come out in numeric order.

The pool holds half the slice width in labels, which is the largest number of segments that can be open at one time in a raster scan. Untouched labels come first, from an incrementing counter. After that, freed labels are reused, lowest number first. A label whose segment has finished may be handed out again at once. A label released because two segments merged may still be sitting in the row buffer. It is therefore held back and joins the pool only at the next end-of-row strobe. When nothing can be handed out, an exhausted flag is raised.

Top module: `lba_label_alloc`

## Requirements
- R1: After reset `grant_vld_o` and `exhausted_o` are low and the row number is 0.
- R2: A request while the fresh counter is below the pool size is answered in the next cycle with `grant_vld_o` high and the counter value, so a fresh pool gives out 0, 1, 2, ... in order.
- R3: `aug_o` is {row number, plain label}. The row number counts end-of-row strobes since reset, modulo 2^ROW_W. A request in the same cycle as a strobe is tagged with the row before the strobe.
- R4: Once the counter is spent, a request is served with the lowest-numbered label in the free pool.
- R5: A label freed by `fin_vld_i` is in the pool from the next cycle. If the pool is empty and the counter is spent, a request in the same cycle as `fin_vld_i` is granted that label directly.
- R6: A label freed by `mrg_vld_i` is not granted before an end-of-row strobe that comes after the cycle in which it was freed. From the cycle after that strobe it is in the pool. A merger release in the same cycle as a strobe waits for the following strobe.
- R7: `exhausted_o` is high exactly when the counter is spent and the pool is empty. A request made while it is high, with no finished label arriving, gets no grant.
- R8: `grant_vld_o` is high only in the cycle after a request.
- R9: The pool size is SLICE_W/2, and the plain label is clog2(SLICE_W/2) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_end_i | input | 1 | End-of-row strobe |
| req_i | input | 1 | New-label request |
| fin_vld_i | input | 1 | A finished segment releases a label |
| fin_lbl_i | input | LBL_W | Label released by finish detection |
| mrg_vld_i | input | 1 | A merger releases a label |
| mrg_lbl_i | input | LBL_W | Label released by a merger |
| grant_vld_o | output | 1 | Granted label is valid this cycle |
| lbl_o | output | LBL_W | Plain label, used for table addressing |
| aug_o | output | ROW_W+LBL_W | Row-tagged label, used for comparisons |
| exhausted_o | output | 1 | No label can be issued |

## Verification
The bench drives the allocator with a small pool. It runs a fresh drain, then finish releases spread over several cycles, which shows the fresh-first order apart from the lowest-free order. A merger release followed by requests before and after a strobe shows the one-row hold apart from immediate reuse, and a merger release that lands on a strobe shows that the hold is not cut short. A request that coincides with a finish release on an empty pool tests the bypass. A request on a strobe, followed by enough strobes to wrap the row field, separates old-row from new-row tagging and checks the wrap.

// File: rtl/lba_pkg.sv
package lba_pkg;
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_FRESH  = 2'd1,
        SRC_POOL   = 2'd2,
        SRC_BYPASS = 2'd3
    } grant_src_e;
endpackage

// File: rtl/lba_first_set.sv
module lba_first_set #(
    parameter int W = 32,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lba_row_ctr.sv
module lba_row_ctr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (adv_i) row_d = row_q + ROW_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row_o = row_q;

    // R3
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> row_q == $past(row_q) + ROW_W'(1));
endmodule

// File: rtl/lba_label_alloc.sv
module lba_label_alloc
    import lba_pkg::*;
#(
    parameter int SLICE_W = 64,
    parameter int ROW_W   = 10,
    localparam int NLBL   = SLICE_W / 2,
    localparam int LBL_W  = $clog2(NLBL),
    localparam int CNT_W  = $clog2(NLBL + 1),
    localparam int AUG_W  = ROW_W + LBL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_end_i,
    input  logic             req_i,
    input  logic             fin_vld_i,
    input  logic [LBL_W-1:0] fin_lbl_i,
    input  logic             mrg_vld_i,
    input  logic [LBL_W-1:0] mrg_lbl_i,
    output logic             grant_vld_o,
    output logic [LBL_W-1:0] lbl_o,
    output logic [AUG_W-1:0] aug_o,
    output logic             exhausted_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [NLBL-1:0]  free;
        logic [NLBL-1:0]  pend;
        logic             gv;
        logic [LBL_W-1:0] glbl;
        logic [ROW_W-1:0] grow;
    } state_t;

    state_t st_d, st_q;

    logic [ROW_W-1:0] row;
    logic             pool_found;
    logic [LBL_W-1:0] pool_idx;
    logic [NLBL-1:0]  fin_dec, mrg_dec;
    grant_src_e       src;

    lba_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (row_end_i),
        .row_o (row)
    );

    lba_first_set #(.W(NLBL)) u_pick (
        .vec_i   (st_q.free),
        .found_o (pool_found),
        .idx_o   (pool_idx)
    );

    for (genvar g = 0; g < NLBL; g++) begin : g_dec
        assign fin_dec[g] = fin_vld_i && (fin_lbl_i == LBL_W'(g));
        assign mrg_dec[g] = mrg_vld_i && (mrg_lbl_i == LBL_W'(g));
    end

    assign exhausted_o = (st_q.cnt == CNT_W'(NLBL)) && !pool_found;

    always_comb begin
        logic [NLBL-1:0]  take;
        logic [LBL_W-1:0] pick;
        st_d = st_q;
        src  = SRC_NONE;
        pick = '0;
        if (req_i) begin
            if (st_q.cnt < CNT_W'(NLBL)) begin
                src      = SRC_FRESH;
                pick     = st_q.cnt[LBL_W-1:0];
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else if (pool_found) begin
                src  = SRC_POOL;
                pick = pool_idx;
            end else if (fin_vld_i) begin
                src  = SRC_BYPASS;
                pick = fin_lbl_i;
            end
        end
        take = (src == SRC_POOL) ? (NLBL'(1) << pick) : '0;
        st_d.free = (st_q.free & ~take)
                  | ((src == SRC_BYPASS) ? '0 : fin_dec)
                  | (row_end_i ? st_q.pend : '0);
        st_d.pend = (row_end_i ? '0 : st_q.pend) | mrg_dec;
        st_d.gv   = (src != SRC_NONE);
        st_d.glbl = pick;
        st_d.grow = row;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_vld_o = st_q.gv;
    assign lbl_o       = st_q.glbl;
    assign aug_o       = {st_q.grow, st_q.glbl};

    // R2
    fresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && st_q.cnt < CNT_W'(NLBL)) |=>
            (grant_vld_o && lbl_o == $past(st_q.cnt[LBL_W-1:0])));
    // R3
    row_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> aug_o[AUG_W-1:LBL_W] == $past(row));
    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> !(|($past(st_q.pend) & (NLBL'(1) << lbl_o))));
    // R7
    exhausted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted_o && req_i && !fin_vld_i) |=> !grant_vld_o);
    // R8
    no_req_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_i) |-> !grant_vld_o);
endmodule

// File: tb/sim_lba_label_alloc.sv
module sim_lba_label_alloc;
    localparam int SW = 8;
    localparam int RW = 4;
    localparam int N  = SW / 2;
    localparam int LW = 2;

    typedef struct {
        bit    vld;
        int    lbl;
        int    aug;
        bit    exh;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_end = 1'b0, req = 1'b0, fin_vld = 1'b0, mrg_vld = 1'b0;
    logic [LW-1:0] fin_lbl = '0, mrg_lbl = '0;
    logic grant_vld, exhausted;
    logic [LW-1:0] lbl;
    logic [RW+LW-1:0] aug;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    bit [N-1:0] mfree = '0;
    bit [N-1:0] mpend = '0;
    int mcnt = 0;
    int mrow = 0;

    always #5 clk = ~clk;

    lba_label_alloc #(.SLICE_W(SW), .ROW_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .row_end_i(row_end), .req_i(req),
        .fin_vld_i(fin_vld), .fin_lbl_i(fin_lbl), .mrg_vld_i(mrg_vld),
        .mrg_lbl_i(mrg_lbl), .grant_vld_o(grant_vld), .lbl_o(lbl),
        .aug_o(aug), .exhausted_o(exhausted)
    );

    task automatic step(input bit r, input bit fv, input int fl,
                        input bit mv, input int ml, input bit re, input string tag);
        exp_t e;
        bit bypass = 0;
        req = r; fin_vld = fv; fin_lbl = LW'(fl);
        mrg_vld = mv; mrg_lbl = LW'(ml); row_end = re;
        e.vld = 0; e.lbl = 0; e.tag = tag;
        if (r) begin
            if (mcnt < N) begin
                e.vld = 1; e.lbl = mcnt; mcnt++;
            end else if (mfree != 0) begin
                for (int i = N - 1; i >= 0; i--) if (mfree[i]) e.lbl = i;
                e.vld = 1; mfree[e.lbl] = 0;
            end else if (fv) begin
                e.vld = 1; e.lbl = fl; bypass = 1;
            end
        end
        e.aug = (mrow % (1 << RW)) * (1 << LW) + e.lbl;
        if (fv && !bypass) mfree[fl] = 1;
        if (re) begin
            mfree |= mpend; mpend = '0; mrow++;
        end
        if (mv) mpend[ml] = 1;
        e.exh = (mcnt == N) && (mfree == 0);
        @(posedge clk);
        q.push_back(e);
        @(negedge clk);
        req = 0; fin_vld = 0; mrg_vld = 0; row_end = 0;
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (grant_vld !== e.vld || (e.vld && (int'(lbl) != e.lbl || int'(aug) != e.aug))) begin
                fails++;
                $display("FAIL %s grant vld/lbl/aug act %0b/%0d/%0d exp %0b/%0d/%0d",
                         e.tag, grant_vld, lbl, aug, e.vld, e.lbl, e.aug);
            end
            checks++;
            if (exhausted !== e.exh) begin
                fails++;
                $display("FAIL %s exhausted act %0b exp %0b", e.tag, exhausted, e.exh);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act hung exp finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (grant_vld !== 1'b0 || exhausted !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset vld/exh act %0b/%0b exp 0/0", grant_vld, exhausted);
        end
        for (int i = 0; i < N; i++) step(1, 0, 0, 0, 0, 0, "R2 fresh");
        step(1, 0, 0, 0, 0, 0, "R7 exhausted req");
        step(0, 0, 0, 0, 0, 0, "R8 idle");
        step(0, 0, 0, 1, 2, 0, "R6 merge free");
        step(1, 0, 0, 0, 0, 0, "R6 held back");
        step(0, 1, 1, 0, 0, 0, "R5 finish free");
        step(1, 0, 0, 0, 0, 0, "R5 reuse");
        step(0, 0, 0, 0, 0, 1, "R6 row end");
        step(1, 0, 0, 0, 0, 0, "R6 released");
        step(0, 1, 3, 0, 0, 0, "R4 free 3");
        step(0, 1, 0, 0, 0, 0, "R4 free 0");
        step(1, 0, 0, 0, 0, 0, "R4 lowest");
        step(1, 0, 0, 0, 0, 0, "R4 next");
        step(1, 1, 1, 0, 0, 0, "R5 bypass");
        step(0, 1, 1, 0, 0, 0, "R3 prep");
        step(1, 0, 0, 0, 0, 1, "R3 req on row end");
        for (int i = 0; i < 14; i++) step(0, 0, 0, 0, 0, 1, "R3 rows");
        step(0, 1, 2, 0, 0, 0, "R3 prep wrap");
        step(1, 0, 0, 0, 0, 0, "R3 wrap tag");
        step(0, 0, 0, 1, 0, 1, "R6 merge on row end");
        step(1, 0, 0, 0, 0, 0, "R6 still held");
        step(0, 0, 0, 0, 0, 1, "R6 second row end");
        step(1, 0, 0, 0, 0, 0, "R6 released late R9");
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule